// File: doc/BRIEF.md
# Four-Channel ADC Control Word Sequencer

This block holds the digital control side of a four-channel serial converter and acts as an SPI slave. A host frames each transfer with a low chip select and 16 serial clocks. During that frame the block takes in a 16-bit control word, most significant bit first, and sends out a 16-bit result word. The result word carries the number of the channel that was converted and the 12-bit sample for that channel. A 12-bit parallel input stands in for the analog core. The block reports the channel it will convert next on a 2-bit output, so the core can present the matching sample.

The control word picks one of two ways to choose channels. In fixed mode every frame converts the addressed channel. In sequencing mode the channels are converted in rising order, starting at channel 0 and ending at a programmed last channel, and the order then wraps back to channel 0. Once a sequence is running, it keeps going across frames that do not write the register. It also keeps going across writes that carry the "keep" mode code. A write with any other mode code ends the sequence.

SPI inputs are resynchronised to the system clock. SCLK idles low. The block drives MISO on the falling edge of SCLK and samples MOSI on the rising edge.

Top module: `adc_seq_spi`

## Requirements
- R1: After reset, `sample_chan` is 0, no sequence is running, each frame converts channel 0, and `spi_miso` is 0.
- R2: The control word layout is: bit 15 write enable, bits 14:13 mode, bits 12:11 address, bits 10:0 ignored. The word takes effect after its 16th rising SCLK. Mode 00 or 01 selects fixed mode, in which every later frame converts the addressed channel. Mode 10 also selects fixed mode when no sequence is running.
- R3: The result word is 16 bits, sent MSB first: bits 15:14 are 0, bits 13:12 are the converted channel, and bits 11:0 are the sample. Bit 15 appears on `spi_miso` after chip select falls, and each falling SCLK moves out the next bit. `spi_miso` is 0 while chip select is high.
- R4: The sample and the channel number are captured when chip select falls. Later changes on `sample_data` do not alter that frame's result.
- R5: A write with mode 11 starts a sequence whose last channel is the written address. The next frame converts channel 0, and each later frame converts the next higher channel.
- R6: After the frame that converts the last channel, the sequence wraps to channel 0 without any further write.
- R7: A word with write enable 0 changes no setting. In fixed mode the channel stays the same. A running sequence keeps stepping.
- R8: While a sequence runs, a write with mode 10 does not interrupt it. The address it carries is ignored, and the stored last channel is kept.
- R9: While a sequence runs, a write with mode 00 or 01 ends the sequence, and the next frame converts the written address.
- R10: A frame that ends with fewer than 16 rising SCLK edges leaves the channel and the sequence state unchanged.
- R11: `sample_chan` always shows the channel that the next frame will convert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_mosi | input | 1 | Control word in, sampled on rising SCLK |
| spi_miso | output | 1 | Result word out, changes on falling SCLK |
| sample_data | input | 12 | Conversion result from the analog stand-in |
| sample_chan | output | 2 | Channel the next frame will convert |

## Verification
The assertions check the channel-update rules on every cycle. They cover the start of a sequence, single steps and the wrap to 0, the hold when the write enable is clear, the stop on mode 00 or 01, and the fact that nothing moves between completed frames. They also check that the leading result bit is 0 and that MISO stays low while the frame is idle. Only the bench scenarios can show the full serial picture. These include the bit order of the result word, the capture of the sample at chip select fall despite later changes, the ignored low control bits, the effect of a keep-mode write over several frames, and an aborted frame followed by a resumed sequence.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CHAN_W = 2;
    localparam int DATA_W = 12;
    localparam int WORD_W = 16;
    localparam int PAD_W  = WORD_W - CHAN_W - DATA_W;
    localparam int IGN_W  = WORD_W - 3 - CHAN_W;

    typedef logic [CHAN_W-1:0] chan_t;
    typedef logic [DATA_W-1:0] sample_t;

    typedef enum logic [1:0] {
        MODE_FIXED     = 2'b00,
        MODE_FIXED_ALT = 2'b01,
        MODE_KEEP      = 2'b10,
        MODE_SEQ       = 2'b11
    } mode_e;

    typedef struct packed {
        logic             wr_en;
        mode_e            mode;
        chan_t            addr;
        logic [IGN_W-1:0] unused;
    } ctrl_word_t;

    function automatic chan_t seq_step(chan_t cur, chan_t last);
        return (cur == last) ? chan_t'(0) : chan_t'(cur + chan_t'(1));
    endfunction

    function automatic logic [WORD_W-1:0] pack_result(chan_t ch, sample_t d);
        return {{PAD_W{1'b0}}, ch, d};
    endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_chain
            logic [W-1:0] st [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
                end else begin
                    st[0] <= d;
                    for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
                end
            end
            assign q = st[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/adc_seq_frame.sv
module adc_seq_frame #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] load_word,
    output logic              start,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              miso
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic              sclk_q, cs_q, act_q, done_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] rx_q, tx_q, word_q, rx_nxt;
    logic              stop, rise, fall;

    assign start  = cs_q & ~cs_n_s;
    assign stop   = ~cs_q & cs_n_s;
    assign rise   = act_q & ~sclk_q & sclk_s;
    assign fall   = act_q & sclk_q & ~sclk_s;
    assign rx_nxt = {rx_q[WORD_W-2:0], mosi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
            act_q   <= 1'b0;
            done_q  <= 1'b0;
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            word_q  <= '0;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_n_s;
            done_q <= 1'b0;
            if (start) begin
                act_q   <= 1'b1;
                bit_cnt <= '0;
                rx_q    <= '0;
                tx_q    <= load_word;
            end else if (stop) begin
                act_q <= 1'b0;
            end else begin
                if (rise && bit_cnt != CNT_W'(WORD_W)) begin
                    rx_q    <= rx_nxt;
                    bit_cnt <= bit_cnt + CNT_W'(1);
                    if (bit_cnt == CNT_W'(WORD_W - 1)) begin
                        done_q <= 1'b1;
                        word_q <= rx_nxt;
                    end
                end
                if (fall) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            end
        end
    end

    assign done    = done_q;
    assign rx_word = word_q;
    assign miso    = act_q & tx_q[WORD_W-1];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  upd,
    input  logic  wr_en,
    input  mode_e mode,
    input  chan_t addr,
    output chan_t cur_chan,
    output logic  seq_run,
    output chan_t seq_final
);
    chan_t chan_q, final_q;
    logic  run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q  <= '0;
            final_q <= '0;
            run_q   <= 1'b0;
        end else if (upd) begin
            if (wr_en && mode == MODE_SEQ) begin
                run_q   <= 1'b1;
                final_q <= addr;
                chan_q  <= '0;
            end else if (run_q && (!wr_en || mode == MODE_KEEP)) begin
                chan_q <= seq_step(chan_q, final_q);
            end else if (wr_en) begin
                run_q  <= 1'b0;
                chan_q <= addr;
            end
        end
    end

    assign cur_chan  = chan_q;
    assign seq_run   = run_q;
    assign seq_final = final_q;
endmodule

// File: rtl/adc_seq_spi.sv
module adc_seq_spi
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [DATA_W-1:0] sample_data,
    output logic [CHAN_W-1:0] sample_chan
);
    logic [2:0]        pins_s;
    logic              frm_start, frm_done;
    logic [WORD_W-1:0] rx_word, load_word;
    ctrl_word_t        frm_word;
    chan_t             cur_chan, seq_final;
    logic              seq_run;

    adc_seq_sync #(
        .STAGES (SYNC_STAGES),
        .W      (3),
        .RST_VAL(3'b010)
    ) i_sync (
        .clk(clk),
        .rst(rst),
        .d  ({spi_sclk, spi_cs_n, spi_mosi}),
        .q  (pins_s)
    );

    // Result word is built from the live channel and sample; the frame
    // unit captures it on the chip-select fall (R4).
    assign load_word = pack_result(cur_chan, sample_data);

    adc_seq_frame #(.WORD_W(WORD_W)) i_frame (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (pins_s[2]),
        .cs_n_s   (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .load_word(load_word),
        .start    (frm_start),
        .done     (frm_done),
        .rx_word  (rx_word),
        .miso     (spi_miso)
    );

    assign frm_word = ctrl_word_t'(rx_word);

    adc_seq_ctrl i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .upd      (frm_done),
        .wr_en    (frm_word.wr_en),
        .mode     (frm_word.mode),
        .addr     (frm_word.addr),
        .cur_chan (cur_chan),
        .seq_run  (seq_run),
        .seq_final(seq_final)
    );

    assign sample_chan = cur_chan;
endmodule

// File: rtl/adc_seq_spi_chk.sv
module adc_seq_spi_chk
    import adc_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       spi_cs_n,
    input logic       spi_miso,
    input logic       frm_start,
    input logic       frm_done,
    input ctrl_word_t frm_word,
    input chan_t      cur_chan,
    input logic       seq_run,
    input chan_t      seq_final
);
    logic [2:0] cs_hi_cnt;
    logic       keeps;

    always_ff @(posedge clk) begin
        if (rst || !spi_cs_n) cs_hi_cnt <= '0;
        else if (cs_hi_cnt != 3'd7) cs_hi_cnt <= cs_hi_cnt + 3'd1;
    end

    assign keeps = !frm_word.wr_en || frm_word.mode == MODE_KEEP;

    a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
        cs_hi_cnt >= 3'd5 |-> !spi_miso);

    a_r3_lead_zero: assert property (@(posedge clk) disable iff (rst)
        frm_start |=> !spi_miso);

    a_r5_seq_start: assert property (@(posedge clk) disable iff (rst)
        frm_done && frm_word.wr_en && frm_word.mode == MODE_SEQ
        |=> seq_run && cur_chan == '0);

    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        frm_done && seq_run && keeps && cur_chan != seq_final
        |=> cur_chan == $past(cur_chan) + chan_t'(1) && seq_run);

    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        frm_done && seq_run && keeps && cur_chan == seq_final
        |=> cur_chan == '0 && seq_run);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        frm_done && !frm_word.wr_en && !seq_run
        |=> $stable(cur_chan) && !seq_run);

    a_r8_keep_final: assert property (@(posedge clk) disable iff (rst)
        frm_done && seq_run && keeps |=> $stable(seq_final));

    a_r9_stop: assert property (@(posedge clk) disable iff (rst)
        frm_done && frm_word.wr_en && frm_word.mode != MODE_SEQ
        && !(seq_run && frm_word.mode == MODE_KEEP)
        |=> !seq_run && cur_chan == $past(frm_word.addr));

    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        !frm_done |=> $stable(cur_chan) && $stable(seq_run));
endmodule

bind adc_seq_spi adc_seq_spi_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso),
    .frm_start(frm_start),
    .frm_done (frm_done),
    .frm_word (frm_word),
    .cur_chan (cur_chan),
    .seq_run  (seq_run),
    .seq_final(seq_final)
);

// File: tb/test_adc_seq_spi.sv
`timescale 1ns/1ps
module test_adc_seq_spi;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso;
    logic [11:0] sdata = '0;
    logic [1:0]  schan;

    int  n_chk = 0, n_err = 0;
    bit  finished = 0;

    // bench model of the channel rules
    bit       m_run = 0;
    bit [1:0] m_fin = 0, m_ch = 0;

    always #2 clk = ~clk;

    adc_seq_spi i_adc_seq_spi (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .sample_data(sdata),
        .sample_chan(schan)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void model_apply(input logic [15:0] cmd);
        bit we = cmd[15];
        bit [1:0] m = cmd[14:13], a = cmd[12:11];
        if (we && m == 2'b11) begin m_run = 1; m_fin = a; m_ch = 0; end
        else if (m_run && (!we || m == 2'b10)) m_ch = (m_ch == m_fin) ? 2'd0 : m_ch + 2'd1;
        else if (we) begin m_run = 0; m_ch = a; end
    endfunction

    // One frame with nbits clocks; checks result word when complete.
    task automatic frame(input logic [15:0] cmd, input logic [11:0] d,
                         input int nbits, input string req);
        logic [15:0] got = '0;
        bit [1:0] exp_ch = m_ch;
        sdata = d;
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = cmd[15-i];
            clks(HALF);
            got[15-i] = miso;
            if (i == 1) sdata = ~d;
            sclk = 1'b1;
            clks(HALF);
            sclk = 1'b0;
        end
        clks(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        clks(8);
        chk(miso == 1'b0, "R3", "miso idle", miso, 0);
        if (nbits >= 16) begin
            chk(got[15:14] == 2'b00, "R3", "lead zeros", got[15:14], 0);
            chk(got[13:12] == exp_ch, req, "result channel", got[13:12], exp_ch);
            chk(got[11:0] == d, "R4", "result sample", got[11:0], d);
            model_apply(cmd);
        end
        chk(schan == m_ch, "R11", "next channel", schan, m_ch);
    endtask

    task automatic t_reset;
        chk(schan == 2'd0, "R1", "reset channel", schan, 0);
        chk(miso == 1'b0, "R1", "reset miso", miso, 0);
        frame(16'h0000, 12'hA5C, 16, "R1");
    endtask

    task automatic t_fixed;
        frame(16'b1_00_10_00000000000, 12'h123, 16, "R2");
        frame(16'h0000, 12'h456, 16, "R2");
        chk(schan == 2'd2, "R2", "fixed addr 2", schan, 2);
        frame(16'h07FF, 12'h789, 16, "R7");
        chk(schan == 2'd2, "R7", "wr_en 0 holds", schan, 2);
        frame(16'b1_01_11_00000000000, 12'hFFF, 16, "R2");
        frame(16'b1_00_01_11111111111, 12'h001, 16, "R2");
        chk(schan == 2'd1, "R2", "low bits ignored", schan, 1);
        frame(16'b1_10_00_00000000000, 12'h800, 16, "R2");
        chk(schan == 2'd0, "R2", "mode 10 idle fixed", schan, 0);
    endtask

    task automatic t_seq;
        frame(16'b1_11_10_00000000000, 12'h321, 16, "R5");
        chk(schan == 2'd0, "R5", "seq starts at 0", schan, 0);
        frame(16'h0000, 12'h111, 16, "R5");
        frame(16'h0000, 12'h222, 16, "R5");
        frame(16'h0000, 12'h333, 16, "R6");
        chk(schan == 2'd0, "R6", "wrap to 0", schan, 0);
        frame(16'h0000, 12'h444, 16, "R6");
    endtask

    task automatic t_keep;
        frame(16'b1_10_11_00000000000, 12'h5A5, 16, "R8");
        chk(schan == 2'd2, "R8", "keep step", schan, 2);
        frame(16'h0000, 12'h6B6, 16, "R8");
        chk(schan == 2'd0, "R8", "final kept at 2", schan, 0);
    endtask

    task automatic t_stop;
        frame(16'b1_00_11_00000000000, 12'h7C7, 16, "R9");
        chk(schan == 2'd3, "R9", "stop to addr 3", schan, 3);
        frame(16'h0000, 12'h8D8, 16, "R9");
        frame(16'h0000, 12'h9E9, 16, "R9");
        chk(schan == 2'd3, "R9", "no stepping after stop", schan, 3);
        frame(16'b1_11_01_00000000000, 12'h0F0, 16, "R5");
        frame(16'h0000, 12'h1E1, 16, "R5");
        frame(16'b1_01_10_00000000000, 12'h2D2, 16, "R9");
        chk(schan == 2'd2, "R9", "mode 01 stops", schan, 2);
    endtask

    task automatic t_cut;
        frame(16'b1_11_01_00000000000, 12'h3C3, 16, "R5");
        frame(16'h0000, 12'h4B4, 16, "R5");
        chk(schan == 2'd1, "R10", "before cut", schan, 1);
        frame(16'b1_00_11_00000000000, 12'h000, 8, "R10");
        chk(schan == 2'd1, "R10", "cut frame ignored", schan, 1);
        frame(16'b1_00_11_00000000000, 12'h000, 15, "R10");
        frame(16'h0000, 12'h5A5, 16, "R10");
        chk(schan == 2'd0, "R10", "seq resumes", schan, 0);
    endtask

    initial begin
        clks(5);
        rst = 1'b0;
        clks(10);
        t_reset;
        t_fixed;
        t_seq;
        t_keep;
        t_stop;
        t_cut;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule